// File: doc/BRIEF.md
# Variable-Length Maximal-Sequence LFSR

This block is a pseudo-random bit generator built on a shift register whose active size can be changed at run time anywhere from 2 to 32 bits. For each size it supplies its own feedback tap set from an internal table, so every size runs through a maximal-length sequence of 2^m − 1 states. Feedback is either the XOR or the XNOR of the tap bits, chosen by a mode input.

The starting state is written serially. While the load control is high the block behaves as a plain 32-bit shift register fed from the serial data input, and the size input has no effect. After 32 load edges the full 32-bit value is in place. On the first edge with load low the block captures the size input, applies the matching taps and takes its first sequence step from the loaded value. A lockup flag reports when the active bits hold the one state from which the chosen feedback mode cannot leave.

Top module: `vlfsr_gen`

## Requirements
- R1: While synchronous reset `rst` is high, each clock edge sets the state to all ones when `xnor_i` is 0 (all zeros when 1) and the active size to 32; after reset in XOR mode `state_o` reads 32'hFFFFFFFF, `bit_o` reads 1 and `lockup_o` reads 0.
- R2: On each edge with `load_i` high the state shifts up by one bit with `sin_i` entering bit 0 and no feedback, and the active size is 32 whatever `len_i` holds; after 32 such edges `state_o` equals the 32 bits sent, the first bit sent in bit 31.
- R3: On the first edge with `load_i` low the size becomes m = `len_i` + 1 and the state becomes the loaded value stepped once: bits shift up by one, bit 0 takes the feedback, and bits m and above are cleared.
- R4: In XOR mode (`xnor_i` = 0) and from any state whose low m bits are not all zeros, the state returns to itself after exactly 2^m − 1 steps for every m; a `len_i` of 0 is treated as 1 (m = 2).
- R5: In XNOR mode (`xnor_i` = 1) and from any state whose low m bits are not all ones, the period is likewise exactly 2^m − 1.
- R6: With `load_i` low, `state_o` bits at positions m and above read 0 after each step, and `bit_o` equals `state_o` bit m − 1.
- R7: `lockup_o` is 1 exactly when the low m bits of the state are all zeros in XOR mode or all ones in XNOR mode, and a locked state stays unchanged while size and mode are held.
- R8: A new `len_i` value takes effect on the very edge that captures it: that step already uses the new size and taps.
- R9: The feedback bit is the XOR (XNOR in XNOR mode) of the state bits at tap positions, tap k meaning bit k − 1; the taps are 2,1 for m = 2, 3,2 for m = 3, 4,3 for m = 4, 8,6,5,4 for m = 8, 16,15,13,4 for m = 16 and 32,22,2,1 for m = 32.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| len_i | input | 5 | Size select, active size m = value + 1 |
| load_i | input | 1 | Serial initial-value load enable |
| sin_i | input | 1 | Serial data bit shifted in during load |
| xnor_i | input | 1 | Feedback mode: 0 XOR, 1 XNOR |
| bit_o | output | 1 | Serial output, top bit of the active register |
| state_o | output | 32 | Active register contents, unused upper bits zero |
| lockup_o | output | 1 | Active bits hold the non-advancing state |

## Verification
The bench measures the period for sizes 2, 3, 5, 7, 8, 12 and 16 in XOR mode and 4, 7 and 10 in XNOR mode, and a wrong entry in the tap table shows up as a short period or a state that never repeats within 2^m steps. It loads a pattern bit by bit with a small size held on `len_i`, so a block that let the size leak into the load, or put the first bit at the wrong end, would read back a different value. The first step after load and a size change mid-run are compared with a feedback bit worked out from the stated taps, which catches a block that applies the new size one edge late. The locked states are loaded deliberately in both modes to confirm that the flag rises and the state holds still.

// File: rtl/vlfsr_pkg.sv
package vlfsr_pkg;

    localparam int SR_W  = 32;
    localparam int LEN_W = 5;

    typedef struct packed {
        logic [SR_W-1:0]  sr;
        logic [LEN_W-1:0] len;
    } vlfsr_regs_t;

    // One bit set for tap position k (1-based); k = 0 means no tap.
    function automatic logic [SR_W-1:0] tap_bit(input int k);
        logic [SR_W-1:0] r;
        r = '0;
        if (k > 0) r[k-1] = 1'b1;
        return r;
    endfunction

    function automatic logic [SR_W-1:0] taps4(input int a, input int b,
                                               input int c, input int d);
        return tap_bit(a) | tap_bit(b) | tap_bit(c) | tap_bit(d);
    endfunction

    // Maximal-length tap set for size len + 1.
    function automatic logic [SR_W-1:0] tap_mask(input logic [LEN_W-1:0] len);
        logic [SR_W-1:0] m;
        case (len)
            5'd0, 5'd1: m = taps4( 2,  1,  0, 0);
            5'd2:       m = taps4( 3,  2,  0, 0);
            5'd3:       m = taps4( 4,  3,  0, 0);
            5'd4:       m = taps4( 5,  3,  0, 0);
            5'd5:       m = taps4( 6,  5,  0, 0);
            5'd6:       m = taps4( 7,  6,  0, 0);
            5'd7:       m = taps4( 8,  6,  5, 4);
            5'd8:       m = taps4( 9,  5,  0, 0);
            5'd9:       m = taps4(10,  7,  0, 0);
            5'd10:      m = taps4(11,  9,  0, 0);
            5'd11:      m = taps4(12,  6,  4, 1);
            5'd12:      m = taps4(13,  4,  3, 1);
            5'd13:      m = taps4(14,  5,  3, 1);
            5'd14:      m = taps4(15, 14,  0, 0);
            5'd15:      m = taps4(16, 15, 13, 4);
            5'd16:      m = taps4(17, 14,  0, 0);
            5'd17:      m = taps4(18, 11,  0, 0);
            5'd18:      m = taps4(19,  6,  2, 1);
            5'd19:      m = taps4(20, 17,  0, 0);
            5'd20:      m = taps4(21, 19,  0, 0);
            5'd21:      m = taps4(22, 21,  0, 0);
            5'd22:      m = taps4(23, 18,  0, 0);
            5'd23:      m = taps4(24, 23, 22, 17);
            5'd24:      m = taps4(25, 22,  0, 0);
            5'd25:      m = taps4(26,  6,  2, 1);
            5'd26:      m = taps4(27,  5,  2, 1);
            5'd27:      m = taps4(28, 25,  0, 0);
            5'd28:      m = taps4(29, 27,  0, 0);
            5'd29:      m = taps4(30,  6,  4, 1);
            5'd30:      m = taps4(31, 28,  0, 0);
            default:    m = taps4(32, 22,  2, 1);
        endcase
        return m;
    endfunction

endpackage

// File: rtl/vlfsr_taps.sv
module vlfsr_taps
    import vlfsr_pkg::*;
(
    input  logic [LEN_W-1:0] len,
    output logic [SR_W-1:0]  taps,
    output logic [SR_W-1:0]  act
);
    localparam logic [SR_W-1:0] LOW_CLR = {{(SR_W-1){1'b1}}, 1'b0};

    always_comb begin
        taps = tap_mask(len);
        // len + 1 low bits set; len = 31 yields all ones
        act  = ~(LOW_CLR << len);
    end
endmodule

// File: rtl/vlfsr_next.sv
module vlfsr_next
    import vlfsr_pkg::*;
(
    input  logic [SR_W-1:0] sr,
    input  logic [SR_W-1:0] taps,
    input  logic [SR_W-1:0] act,
    input  logic            xnor_mode,
    output logic [SR_W-1:0] nxt
);
    logic fb;

    always_comb begin
        fb  = (^(sr & taps)) ^ xnor_mode;
        nxt = {sr[SR_W-2:0], fb} & act;
    end
endmodule

// File: rtl/vlfsr_lock.sv
module vlfsr_lock
    import vlfsr_pkg::*;
(
    input  logic [SR_W-1:0] sr,
    input  logic [SR_W-1:0] act,
    input  logic            xnor_mode,
    output logic            locked
);
    logic [SR_W-1:0] live;

    always_comb begin
        live   = sr & act;
        locked = xnor_mode ? (live == act) : (live == '0);
    end
endmodule

// File: rtl/vlfsr_gen.sv
module vlfsr_gen
    import vlfsr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [LEN_W-1:0] len_i,
    input  logic             load_i,
    input  logic             sin_i,
    input  logic             xnor_i,
    output logic             bit_o,
    output logic [SR_W-1:0]  state_o,
    output logic             lockup_o
);
    localparam logic [LEN_W-1:0] LEN_FULL = LEN_W'(SR_W - 1);

    vlfsr_regs_t r_d, r_q;

    logic [LEN_W-1:0] len_eff;
    logic [SR_W-1:0]  taps_new, act_new;
    logic [SR_W-1:0]  taps_cur, act_cur;
    logic [SR_W-1:0]  step_val;

    // A size of one is not supported; map it onto two.
    assign len_eff = (len_i == '0) ? LEN_W'(1) : len_i;

    vlfsr_taps u_taps_new (
        .len  (len_eff),
        .taps (taps_new),
        .act  (act_new)
    );

    vlfsr_taps u_taps_cur (
        .len  (r_q.len),
        .taps (taps_cur),
        .act  (act_cur)
    );

    vlfsr_next u_next (
        .sr        (r_q.sr),
        .taps      (taps_new),
        .act       (act_new),
        .xnor_mode (xnor_i),
        .nxt       (step_val)
    );

    vlfsr_lock u_lock (
        .sr        (r_q.sr),
        .act       (act_cur),
        .xnor_mode (xnor_i),
        .locked    (lockup_o)
    );

    always_comb begin
        r_d = r_q;
        if (load_i) begin
            r_d.sr  = {r_q.sr[SR_W-2:0], sin_i};
            r_d.len = LEN_FULL;
        end else begin
            r_d.sr  = step_val;
            r_d.len = len_eff;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q.sr  <= {SR_W{~xnor_i}};
            r_q.len <= LEN_FULL;
        end else begin
            r_q <= r_d;
        end
    end

    assign state_o = r_q.sr & act_cur;
    assign bit_o   = |(state_o & ~(act_cur >> 1));

    // R2: load is a plain shift with serial data entering at bit 0
    p_load_shift_r2: assert property (@(posedge clk) disable iff (rst)
        load_i |=> (r_q.sr == {$past(r_q.sr[SR_W-2:0]), $past(sin_i)}));

    // R2: load forces the full size
    p_load_size_r2: assert property (@(posedge clk) disable iff (rst)
        load_i |=> (r_q.len == LEN_FULL));

    // R6: bits above the active size are cleared by every step
    p_upper_zero_r6: assert property (@(posedge clk) disable iff (rst)
        !load_i |=> ((r_q.sr & ~act_cur) == '0));

    // R7: a locked state does not move while size and mode hold
    p_lock_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (!load_i && lockup_o && (len_i == r_q.len) && !$isunknown(xnor_i))
        |=> (r_q.sr == $past(r_q.sr)));

    // R8: a nonzero size value is captured on the stepping edge
    p_len_capture_r8: assert property (@(posedge clk) disable iff (rst)
        (!load_i && (len_i != '0)) |=> (r_q.len == $past(len_i)));

endmodule

// File: tb/vlfsr_gen_tb.sv
module vlfsr_gen_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic [4:0]  len_i;
    logic        load_i;
    logic        sin_i;
    logic        xnor_i;
    logic        bit_o;
    logic [31:0] state_o;
    logic        lockup_o;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #2 clk = ~clk;

    vlfsr_gen u_dut (
        .clk      (clk),
        .rst      (rst),
        .len_i    (len_i),
        .load_i   (load_i),
        .sin_i    (sin_i),
        .xnor_i   (xnor_i),
        .bit_o    (bit_o),
        .state_o  (state_o),
        .lockup_o (lockup_o)
    );

    task automatic chk(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Inputs change at the falling edge; outputs read at the next falling edge.
    task automatic tick();
        @(negedge clk);
    endtask

    task automatic load_word(input logic [31:0] v, input logic [4:0] hold_len);
        load_i = 1'b1;
        len_i  = hold_len;
        for (int i = 31; i >= 0; i--) begin
            sin_i = v[i];
            tick();
        end
    endtask

    task automatic period_run(input logic [4:0] len, input bit xm,
                              input logic [31:0] seed, input string req);
        int m;
        int limit;
        int cnt;
        logic [31:0] start;
        m      = (len == 0) ? 2 : int'(len) + 1;
        xnor_i = xm;
        load_word(seed, 5'd31);
        load_i = 1'b0;
        len_i  = len;
        tick();
        start = state_o;
        limit = (1 << m) + 4;
        cnt   = 0;
        for (int k = 0; k < limit; k++) begin
            tick();
            cnt++;
            if (state_o == start) break;
        end
        chk(cnt == (1 << m) - 1, req, 32'(cnt), 32'((1 << m) - 1));
    endtask

    initial begin
        logic [31:0] v;
        logic [31:0] s;
        logic [31:0] e;
        rst = 1'b1; load_i = 1'b0; sin_i = 1'b0; len_i = 5'd3; xnor_i = 1'b0;
        repeat (3) tick();
        rst = 1'b0;
        chk(state_o == 32'hFFFF_FFFF, "R1 reset state", state_o, 32'hFFFF_FFFF);
        chk(bit_o == 1'b1, "R1 reset bit", 32'(bit_o), 32'd1);
        chk(lockup_o == 1'b0, "R1 reset lockup", 32'(lockup_o), 32'd0);

        // R2: serial load with a small size held on len_i
        v = 32'hA5C3_0F1E;
        load_word(v, 5'd2);
        chk(state_o == v, "R2 loaded value", state_o, v);
        chk(bit_o == v[31], "R2 top bit while loading", 32'(bit_o), 32'(v[31]));

        // R3 / R9: first step after load, m = 8, taps 8,6,5,4
        load_i = 1'b0;
        len_i  = 5'd7;
        tick();
        e = {24'd0, v[6:0], v[7] ^ v[5] ^ v[4] ^ v[3]};
        chk(state_o == e, "R3 first step after load", state_o, e);
        chk(bit_o == e[7], "R6 serial bit m-1", 32'(bit_o), 32'(e[7]));

        // R6: upper bits zero and bit_o tracks bit m-1 over several steps
        for (int k = 0; k < 6; k++) begin
            tick();
            chk((state_o & 32'hFFFF_FF00) == 0, "R6 upper bits clear",
                state_o, state_o & 32'hFF);
            chk(bit_o == state_o[7], "R6 serial bit", 32'(bit_o), 32'(state_o[7]));
        end

        // R8 / R9: switch from m = 16 to m = 4 mid-run, taps 4,3
        len_i = 5'd15;
        repeat (5) tick();
        s = state_o;
        len_i = 5'd3;
        tick();
        e = {28'd0, s[2:0], s[3] ^ s[2]};
        chk(state_o == e, "R8 size change on capture edge", state_o, e);
        chk(lockup_o == 1'b0, "R7 no lockup in normal run", 32'(lockup_o), 32'd0);

        // R9: m = 2 step from loaded value, taps 2,1
        v = 32'h0000_0001;
        load_word(v, 5'd31);
        load_i = 1'b0;
        len_i  = 5'd1;
        tick();
        e = 32'h0000_0003;
        chk(state_o == e, "R9 m=2 step", state_o, e);

        // R4: XOR mode periods
        period_run(5'd1,  1'b0, 32'h0000_0001, "R4 period m=2");
        period_run(5'd0,  1'b0, 32'h0000_0001, "R4 period len 0 as m=2");
        period_run(5'd2,  1'b0, 32'h0000_0001, "R4 period m=3");
        period_run(5'd4,  1'b0, 32'h0000_0001, "R4 period m=5");
        period_run(5'd6,  1'b0, 32'h0000_0001, "R4 period m=7");
        period_run(5'd7,  1'b0, 32'h0000_0001, "R4 period m=8");
        period_run(5'd11, 1'b0, 32'h0000_0001, "R4 period m=12");
        period_run(5'd15, 1'b0, 32'h0000_0001, "R4 period m=16");

        // R5: XNOR mode periods
        period_run(5'd3,  1'b1, 32'h0000_0000, "R5 period m=4");
        period_run(5'd6,  1'b1, 32'h0000_0000, "R5 period m=7");
        period_run(5'd9,  1'b1, 32'h0000_0000, "R5 period m=10");

        // R7: XOR lockup on all zeros
        xnor_i = 1'b0;
        load_word(32'h0, 5'd31);
        load_i = 1'b0;
        len_i  = 5'd3;
        tick();
        chk(lockup_o == 1'b1, "R7 XOR lockup flag", 32'(lockup_o), 32'd1);
        repeat (4) tick();
        chk(state_o == 32'h0, "R7 XOR locked state holds", state_o, 32'h0);

        // R7: XNOR lockup on all ones
        xnor_i = 1'b1;
        load_word(32'hFFFF_FFFF, 5'd31);
        load_i = 1'b0;
        len_i  = 5'd3;
        tick();
        chk(lockup_o == 1'b1, "R7 XNOR lockup flag", 32'(lockup_o), 32'd1);
        repeat (4) tick();
        chk(state_o == 32'hF, "R7 XNOR locked state holds", state_o, 32'hF);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule